// File: doc/BRIEF.md
# Lock-Qualified Reset Generator

This block turns a PLL lock flag, which can toggle several times while the PLL is still acquiring, into a clean reset for the rest of the chip. A counter clears whenever lock is low and advances only while lock is high. Reset stays asserted until the counter has covered the worst-case acquisition time, given as a number of clock cycles, while lock is still high.

Once the qualification condition is met, the release travels through a short chain of flops clocked by the same clock, so it is a synchronous path that timing analysis can check. The last flop of the chain is built several times so that each copy drives part of a large fan-out. Reset is asserted again at once, without waiting for a clock, when lock drops or when the external start pulse `por_i` is high. Reset is also asserted for the first clock cycle after the device starts, through a register initial value. The output polarity is set by a parameter.

Top module: `lock_reset_gen`

## Requirements
- R1: While `lock_raw` is low, every output copy shows reset asserted. The output is high-level for reset when `ACTIVE_LOW`=0, and low-level for reset when `ACTIVE_LOW`=1.
- R2: The qualification counter is cleared whenever `lock_raw` is low and advances only while it is high. A low pulse of any length, even one cycle, restarts the window from zero.
- R3: With `lock_raw` held high from a cleared state, reset releases after exactly `LOCK_CYCLES`+`STAGES` rising clock edges, and not one edge sooner.
- R4: The counter saturates at `LOCK_CYCLES` and does not wrap. While `lock_raw` stays high, reset stays released for any length of time.
- R5: If `lock_raw` falls after reset has been released, reset is asserted again in the same time step, without waiting for a clock edge. A new full window is then required.
- R6: While `por_i` is high, reset is asserted and the counter is held cleared. A full window counted from the first edge after `por_i` falls is then required. A pulse lasting one cycle after device start, made from a register initial value, has the same clearing effect.
- R7: All `COPIES` output bits always carry the same value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock from the PLL output |
| por_i | input | 1 | Optional external start pulse, active high; tie low if unused |
| lock_raw | input | 1 | Unqualified PLL lock flag |
| rst_o | output | COPIES | Replicated qualified reset, polarity set by ACTIVE_LOW |

## Verification
The bench runs a sweep of lock-high durations from zero up to past the release point, and pulls lock low after each one. A design that counts one edge short or long, or leaves out a pipeline stage, fails at the boundary durations of this sweep. A one-cycle dropout just before release catches a counter that pauses instead of clearing, because such a design would release early. The bench also holds lock high far past the terminal count to catch a counter that wraps and drops the release, checks the output in the same time step that lock falls to catch a reassertion that waits for a clock, and runs a second instance with the inverted polarity.

// File: rtl/lock_reset_gen.sv
module lock_reset_gen #(
  parameter int LOCK_CYCLES = 1000,
  parameter int STAGES      = 3,
  parameter int COPIES      = 1,
  parameter bit ACTIVE_LOW  = 1'b0
) (
  input  logic              clk,
  input  logic              por_i,
  input  logic              lock_raw,
  output logic [COPIES-1:0] rst_o
);
  localparam int CW = $clog2(LOCK_CYCLES + 1);
  localparam logic [CW-1:0] TERM = CW'(LOCK_CYCLES);

  logic            boot_q = 1'b1;
  logic            clr;
  logic [CW-1:0]   cnt;
  logic            qual;
  logic [STAGES-2:0] chain;
  logic [STAGES-1:0] src;
  logic [COPIES-1:0] rel;

  always_ff @(posedge clk) boot_q <= 1'b0;

  assign clr = ~lock_raw | por_i | boot_q;

  always_ff @(posedge clk or posedge clr)
    if (clr)              cnt <= '0;
    else if (cnt != TERM) cnt <= cnt + 1'b1;

  assign qual = (cnt == TERM) & lock_raw;
  assign src  = {chain, qual};

  for (genvar i = 0; i < STAGES - 1; i++) begin : g_stage
    always_ff @(posedge clk or posedge clr)
      if (clr) chain[i] <= 1'b0;
      else     chain[i] <= src[i];
  end

  for (genvar c = 0; c < COPIES; c++) begin : g_copy
    always_ff @(posedge clk or posedge clr)
      if (clr) rel[c] <= 1'b0;
      else     rel[c] <= src[STAGES-1];
  end

  if (ACTIVE_LOW) begin : g_low
    assign rst_o = rel;
  end else begin : g_high
    assign rst_o = ~rel;
  end
endmodule

module lock_reset_gen_chk #(
  parameter int LOCK_CYCLES = 1000,
  parameter int STAGES      = 3,
  parameter int COPIES      = 1,
  parameter bit ACTIVE_LOW  = 1'b0,
  parameter int CW          = 10
) (
  input logic              clk,
  input logic              por_i,
  input logic              lock_raw,
  input logic [COPIES-1:0] rst_o,
  input logic [CW-1:0]     cnt
);
  localparam int LIM = LOCK_CYCLES + STAGES;
  localparam int RW  = $clog2(LIM + 1);

  logic [RW-1:0] run = '0;
  logic released;

  assign released = ACTIVE_LOW ? (&rst_o) : ~(|rst_o);

  always_ff @(posedge clk)
    if (!lock_raw || por_i)   run <= '0;
    else if (run != RW'(LIM)) run <= run + 1'b1;

  p_unlocked_in_reset_r1: assert property (@(posedge clk) !lock_raw |-> !released);
  p_no_early_release_r3: assert property (@(posedge clk) disable iff (por_i)
    released |-> run >= RW'(LIM));
  p_saturate_r4: assert property (@(posedge clk) cnt <= CW'(LOCK_CYCLES));
  p_stay_released_r4: assert property (@(posedge clk) disable iff (por_i)
    released && lock_raw |=> released || !lock_raw || por_i);
  p_por_clears_r6: assert property (@(posedge clk) por_i |-> !released && cnt == '0);
  p_copies_agree_r7: assert property (@(posedge clk)
    rst_o == {COPIES{rst_o[0]}});
endmodule

bind lock_reset_gen lock_reset_gen_chk #(
  .LOCK_CYCLES(LOCK_CYCLES), .STAGES(STAGES), .COPIES(COPIES),
  .ACTIVE_LOW(ACTIVE_LOW), .CW(CW)
) u_chk (
  .clk(clk), .por_i(por_i), .lock_raw(lock_raw), .rst_o(rst_o), .cnt(cnt)
);

// File: tb/tb_lock_reset_gen.sv
module tb_lock_reset_gen;
  localparam int N  = 8;
  localparam int S  = 3;
  localparam int NC = 2;

  logic clk = 1'b0;
  logic por = 1'b1;
  logic lock = 1'b0;
  logic [NC-1:0] rst_h, rst_l;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  lock_reset_gen #(.LOCK_CYCLES(N), .STAGES(S), .COPIES(NC), .ACTIVE_LOW(1'b0)) dut (
    .clk(clk), .por_i(por), .lock_raw(lock), .rst_o(rst_h));
  lock_reset_gen #(.LOCK_CYCLES(N), .STAGES(S), .COPIES(NC), .ACTIVE_LOW(1'b1)) dut_n (
    .clk(clk), .por_i(por), .lock_raw(lock), .rst_o(rst_l));

  task automatic expect_rel(input bit exp_rel, input string req);
    logic [NC-1:0] eh, el;
    eh = exp_rel ? '0 : '1;
    el = exp_rel ? '1 : '0;
    checks++;
    if (rst_h !== eh || rst_l !== el) begin
      fails++;
      $display("FAIL %s: high-pol=%b low-pol=%b expected %b/%b", req, rst_h, rst_l, eh, el);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  task automatic lock_low_cycles(input int k);
    @(negedge clk) lock = 1'b0;
    repeat (k) @(negedge clk);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: run hung, expected completion");
      summary();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    expect_rel(1'b0, "R6 reset state under por");
    lock = 1'b1;
    repeat (N + S + 2) @(negedge clk);
    expect_rel(1'b0, "R6 por holds reset with lock high");
    por = 1'b0;
    lock_low_cycles(2);
    expect_rel(1'b0, "R1 unlocked after por");

    // R3 sweep of lock-high durations, R5 immediate reassert after each
    for (int k = 0; k <= N + S + 2; k++) begin
      @(negedge clk) lock = 1'b1;
      repeat (k) @(posedge clk);
      #1 expect_rel(k >= N + S, $sformatf("R3 after %0d locked edges", k));
      lock = 1'b0;
      #1 expect_rel(1'b0, "R5 async reassert on lock drop");
      repeat (2) @(negedge clk);
    end

    // R2 one-cycle dropout just before release restarts the window
    @(negedge clk) lock = 1'b1;
    repeat (N + S - 1) @(posedge clk);
    @(negedge clk) lock = 1'b0;
    @(negedge clk) lock = 1'b1;
    repeat (N + S - 1) @(posedge clk);
    #1 expect_rel(1'b0, "R2 glitch restarted count, no early release");
    @(posedge clk);
    #1 expect_rel(1'b1, "R2 release after full window post glitch");

    // R2 chatter: many short highs never release
    for (int j = 1; j < N + S; j += 3) begin
      @(negedge clk) lock = 1'b0;
      @(negedge clk) lock = 1'b1;
      repeat (j) @(posedge clk);
      #1 expect_rel(1'b0, $sformatf("R2 chatter high %0d edges", j));
    end

    // R4 long hold: saturate, stay released
    lock_low_cycles(1);
    lock = 1'b1;
    repeat (N + S + 200) @(posedge clk);
    #1 expect_rel(1'b1, "R4 stays released during long lock");
    repeat (1 << ($clog2(N + 1))) @(posedge clk);
    #1 expect_rel(1'b1, "R4 no wrap after counter width");

    // R6 por mid-run with lock held high
    @(negedge clk) por = 1'b1;
    #1 expect_rel(1'b0, "R6 por asserts reset at once");
    @(negedge clk) por = 1'b0;
    repeat (N + S - 1) @(posedge clk);
    #1 expect_rel(1'b0, "R6 full window required after por");
    @(posedge clk);
    #1 expect_rel(1'b1, "R6 release after window following por");

    // R1 lock low for a long time
    lock_low_cycles(N + S + 5);
    expect_rel(1'b0, "R1 held in reset while unlocked");

    done = 1;
    summary();
  end
endmodule